// File: doc/BRIEF.md
# Coded Master-to-Slave Interrupt Unit

This unit lets the supervising core of a two-core pair force the worker core into a handler. The worker has no general interrupt input; this coded request is its only interrupt source. The supervisor issues a raise with a 4-bit code. The unit drives the request line and holds the code beside it. One cycle later the worker side forms a handler address from a supervisor-owned table base and the code. It then pulses a program-counter redirect toward that address and saves the worker's current PC.

When the handler's return instruction retires, the worker side pulses a second redirect back to the saved PC and raises its completion line. The supervisor side treats completion as the end of the work and drops the request line on the next clock edge. Completion then falls one cycle after the request line is seen low. While the request line is high its code is frozen, and a supervisor attempt to raise a different code is refused and flagged.

Top module: `rint_unit`

## Requirements
- R1: After a synchronous reset, `ints`, `serviced`, `s_redirect`, `s_in_handler` and `m_code_err` are 0, and the table base is 0.
- R2: A `m_raise` pulse while `ints` is low sets `ints` on the next clock edge, and `ints_code` takes the value of `m_code`.
- R3: While `ints` is high, `ints_code` does not change. A `m_raise` with a code different from `ints_code` gives a one-cycle `m_code_err` pulse on the next edge and leaves the code unchanged.
- R4: A `m_raise` with the same code as the pending one while `ints` is high has no effect: no error and no change to the code.
- R5: The worker accepts a request one edge after `ints` rises, provided `ints` was low in the cycle before. It then pulses `s_redirect` for one cycle with `s_target = base + code*4`: the code sits in address bits 5:2 above the base.
- R6: On acceptance, `s_ret_pc` captures `s_pc` and holds that value until the next acceptance.
- R7: A `s_ret` pulse while `s_in_handler` is high clears `s_in_handler`, pulses `s_redirect` with `s_target = s_ret_pc`, and sets `serviced` on the next edge.
- R8: The supervisor side drops `ints` on the edge after it sees `serviced` high.
- R9: `serviced` falls on the edge after `ints` is seen low.
- R10: A `s_ret` pulse while no handler is active has no effect: no redirect, and `serviced` stays low.
- R11: A write to the table base through `m_base_we` takes effect for every later acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_base_we | input | 1 | Supervisor write strobe for the handler table base |
| m_base_data | input | 32 | New table base value |
| m_raise | input | 1 | Supervisor raise request pulse |
| m_code | input | 4 | Interrupt code for the raise |
| m_code_err | output | 1 | One-cycle flag: code change refused while pending |
| ints | output | 1 | Request line to the worker |
| ints_code | output | 4 | Code held with the request line |
| s_pc | input | 32 | Worker's current program counter |
| s_ret | input | 1 | Handler return instruction retired |
| s_redirect | output | 1 | One-cycle PC redirect strobe |
| s_target | output | 32 | Redirect address |
| s_in_handler | output | 1 | Worker is running a remote handler |
| s_ret_pc | output | 32 | Saved return PC |
| serviced | output | 1 | Worker completion line |

## Verification
A wrong bit in the pending-code register shows up as a wrong redirect address on the very next acceptance. A stuck request or completion flag shows up within one or two cycles as `ints` or `serviced` failing to fall, or as a second entry that never happens. A lost saved PC appears only at the return redirect, so every handler in the bench is held open for several cycles while `s_pc` moves before the return is checked. Stray returns and conflicting raises are each followed by a check that the pending state is intact.

// File: rtl/rint_pkg.sv
package rint_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned CODE_W     = 4;
    localparam int unsigned SLOT_SHIFT = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  valid;
        code_t code;
    } raise_req_t;

    typedef struct packed {
        logic  pulse;
        addr_t target;
    } redirect_t;

    function automatic addr_t slot_offset(input code_t c);
        addr_t wide;
        wide = addr_t'(c);
        return wide << SLOT_SHIFT;
    endfunction

endpackage

// File: rtl/rint_master.sv
module rint_master
    import rint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       base_we,
    input  addr_t      base_data,
    input  raise_req_t req,
    input  logic       done_in,
    output logic       line,
    output code_t      line_code,
    output logic       code_err,
    output addr_t      base
);

    always_ff @(posedge clk) begin
        if (rst) begin
            line      <= 1'b0;
            line_code <= '0;
            code_err  <= 1'b0;
            base      <= '0;
        end else begin
            code_err <= 1'b0;
            if (base_we) begin
                base <= base_data;
            end
            if (line) begin
                if (done_in) begin
                    line <= 1'b0;
                end
                if (req.valid && (req.code != line_code)) begin
                    code_err <= 1'b1;
                end
            end else if (req.valid) begin
                line      <= 1'b1;
                line_code <= req.code;
            end
        end
    end

endmodule

// File: rtl/rint_vector.sv
module rint_vector
    import rint_pkg::*;
(
    input  addr_t base,
    input  code_t code,
    output addr_t handler
);

    always_comb begin
        handler = base + slot_offset(code);
    end

endmodule

// File: rtl/rint_slave.sv
module rint_slave
    import rint_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line,
    input  addr_t     handler,
    input  addr_t     cur_pc,
    input  logic      ret_in,
    output redirect_t redir,
    output logic      in_hdl,
    output addr_t     ret_pc,
    output logic      done
);

    logic prev_low;
    logic accept;
    logic leave;

    assign accept = line && prev_low && !in_hdl && !done;
    assign leave  = in_hdl && ret_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_low <= 1'b1;
            in_hdl   <= 1'b0;
            ret_pc   <= '0;
            done     <= 1'b0;
            redir    <= '0;
        end else begin
            prev_low    <= !line;
            redir.pulse <= 1'b0;
            if (accept) begin
                in_hdl       <= 1'b1;
                ret_pc       <= cur_pc;
                redir.pulse  <= 1'b1;
                redir.target <= handler;
            end else if (leave) begin
                in_hdl       <= 1'b0;
                done         <= 1'b1;
                redir.pulse  <= 1'b1;
                redir.target <= ret_pc;
            end
            if (done && !line) begin
                done <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rint_unit.sv
module rint_unit
    import rint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              m_base_we,
    input  logic [ADDR_W-1:0] m_base_data,
    input  logic              m_raise,
    input  logic [CODE_W-1:0] m_code,
    output logic              m_code_err,
    output logic              ints,
    output logic [CODE_W-1:0] ints_code,
    input  logic [ADDR_W-1:0] s_pc,
    input  logic              s_ret,
    output logic              s_redirect,
    output logic [ADDR_W-1:0] s_target,
    output logic              s_in_handler,
    output logic [ADDR_W-1:0] s_ret_pc,
    output logic              serviced
);

    raise_req_t req;
    redirect_t  redir;
    addr_t      base;
    addr_t      handler;

    assign req.valid = m_raise;
    assign req.code  = m_code;

    rint_master u_master (
        .clk       (clk),
        .rst       (rst),
        .base_we   (m_base_we),
        .base_data (m_base_data),
        .req       (req),
        .done_in   (serviced),
        .line      (ints),
        .line_code (ints_code),
        .code_err  (m_code_err),
        .base      (base)
    );

    rint_vector u_vector (
        .base    (base),
        .code    (ints_code),
        .handler (handler)
    );

    rint_slave u_slave (
        .clk     (clk),
        .rst     (rst),
        .line    (ints),
        .handler (handler),
        .cur_pc  (s_pc),
        .ret_in  (s_ret),
        .redir   (redir),
        .in_hdl  (s_in_handler),
        .ret_pc  (s_ret_pc),
        .done    (serviced)
    );

    assign s_redirect = redir.pulse;
    assign s_target   = redir.target;

endmodule

// File: rtl/rint_unit_chk.sv
module rint_unit_chk
    import rint_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        m_raise,
    input logic [3:0]  m_code,
    input logic        m_code_err,
    input logic        ints,
    input logic [3:0]  ints_code,
    input logic        s_ret,
    input logic        s_redirect,
    input logic [31:0] s_target,
    input logic        s_in_handler,
    input logic [31:0] s_ret_pc,
    input logic        serviced
);

    a_r2_raise_sets_line: assert property (@(posedge clk) disable iff (rst)
        (m_raise && !ints) |=> (ints && ints_code == $past(m_code)));

    a_r3_code_frozen: assert property (@(posedge clk) disable iff (rst)
        ints |=> (!ints || $stable(ints_code)));

    a_r3_flag_on_change: assert property (@(posedge clk) disable iff (rst)
        (ints && m_raise && m_code != ints_code) |=> m_code_err);

    a_r5_entry_follows_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(ints) && !s_in_handler && !serviced) |=> (s_redirect && s_in_handler));

    a_r7_return_to_saved: assert property (@(posedge clk) disable iff (rst)
        (s_in_handler && s_ret) |=> (serviced && s_redirect && s_target == s_ret_pc));

    a_r8_line_drops: assert property (@(posedge clk) disable iff (rst)
        (serviced && ints) |=> !ints);

    a_r9_done_falls: assert property (@(posedge clk) disable iff (rst)
        (serviced && !ints) |=> !serviced);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!s_in_handler && !ints) |=> !s_redirect);

endmodule

bind rint_unit rint_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .m_raise      (m_raise),
    .m_code       (m_code),
    .m_code_err   (m_code_err),
    .ints         (ints),
    .ints_code    (ints_code),
    .s_ret        (s_ret),
    .s_redirect   (s_redirect),
    .s_target     (s_target),
    .s_in_handler (s_in_handler),
    .s_ret_pc     (s_ret_pc),
    .serviced     (serviced)
);

// File: tb/rint_unit_test.sv
module rint_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_base_we = 1'b0;
    logic [31:0] m_base_data = '0;
    logic        m_raise = 1'b0;
    logic [3:0]  m_code = '0;
    logic        m_code_err;
    logic        ints;
    logic [3:0]  ints_code;
    logic [31:0] s_pc = '0;
    logic        s_ret = 1'b0;
    logic        s_redirect;
    logic [31:0] s_target;
    logic        s_in_handler;
    logic [31:0] s_ret_pc;
    logic        serviced;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rint_unit uut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] b);
        m_base_we = 1'b1; m_base_data = b;
        step();
        m_base_we = 1'b0;
    endtask

    // full cycle: raise, entry, hold, return, drop, completion fall
    task automatic t_round(input logic [31:0] b, input logic [3:0] c, input logic [31:0] pc);
        m_raise = 1'b1; m_code = c;
        step();
        m_raise = 1'b0;
        chk("R2 ints", ints, 1);
        chk("R2 code", ints_code, c);
        s_pc = pc;
        step();
        chk("R5 redirect", s_redirect, 1);
        chk("R5 target", s_target, b + {26'd0, c, 2'b00});
        chk("R5 in_handler", s_in_handler, 1);
        chk("R6 ret_pc", s_ret_pc, pc);
        for (int i = 0; i < 3; i++) begin
            s_pc = pc + 32'h100 + i;
            step();
            chk("R5 single pulse", s_redirect, 0);
        end
        chk("R6 ret_pc held", s_ret_pc, pc);
        chk("R3 code held", ints_code, c);
        s_ret = 1'b1;
        step();
        s_ret = 1'b0;
        chk("R7 redirect", s_redirect, 1);
        chk("R7 target", s_target, pc);
        chk("R7 serviced", serviced, 1);
        chk("R7 left handler", s_in_handler, 0);
        step();
        chk("R8 ints dropped", ints, 0);
        chk("R9 serviced still high", serviced, 1);
        step();
        chk("R9 serviced fell", serviced, 0);
        chk("R7 single pulse", s_redirect, 0);
    endtask

    task automatic t_reset();
        chk("R1 ints", ints, 0);
        chk("R1 serviced", serviced, 0);
        chk("R1 redirect", s_redirect, 0);
        chk("R1 in_handler", s_in_handler, 0);
        chk("R1 err", m_code_err, 0);
    endtask

    task automatic t_reset_base();
        // default base is zero: code 2 vectors to address 8
        t_round(32'h0, 4'd2, 32'h0000_0400);
    endtask

    task automatic t_conflict();
        m_raise = 1'b1; m_code = 4'd3;
        step();
        m_code = 4'd5;
        step();
        chk("R3 err pulse", m_code_err, 1);
        chk("R3 code kept", ints_code, 3);
        m_code = 4'd3;
        step();
        m_raise = 1'b0;
        chk("R4 no err same code", m_code_err, 0);
        chk("R4 code kept", ints_code, 3);
        chk("R3 err one cycle", m_code_err, 0);
        chk("R5 handler entered", s_in_handler, 1);
        s_ret = 1'b1;
        step();
        s_ret = 1'b0;
        chk("R7 serviced", serviced, 1);
        step();
        step();
        chk("R9 idle", serviced | ints, 0);
    endtask

    task automatic t_stray();
        s_ret = 1'b1;
        step();
        s_ret = 1'b0;
        chk("R10 no redirect", s_redirect, 0);
        chk("R10 no serviced", serviced, 0);
        step();
        chk("R10 still quiet", s_redirect | serviced, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_reset_base();
        set_base(32'h1000_0000);
        t_round(32'h1000_0000, 4'd15, 32'h0000_2000);
        t_round(32'h1000_0000, 4'd0, 32'h0000_3004);
        set_base(32'h8000_0040); // R11 new base for later entries
        t_round(32'h8000_0040, 4'd9, 32'hDEAD_BEE0);
        t_conflict();
        t_stray();
        finished = 1'b1;
    end

    initial begin
        for (int n = 0; n < 20000 && !finished; n++) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule